// File: doc/BRIEF.md
# Radio Transceiver SPI Access Decoder

This block is the serial front door of a radio transceiver core. A host talks to it as an SPI slave in mode 0 (clock idles low, data sampled on the rising clock edge, most significant bit first). Each chip-select frame opens with a command byte. The command byte selects one of three kinds of access: a read of one 8-bit register, a write of one 8-bit register, or a streamed access to a 128-byte frame buffer that holds one radio frame.

The block runs entirely on the core clock. The SPI pins are brought in through synchronizers and edge detectors, so the serial clock must be several times slower than the core clock. The register space has 64 entries. Four of them hold fixed identification values. One holds interrupt flags that the core sets and that a host read clears.

The core has three other connections. A plain combinational port lets it view any register. A receive-side port lets the radio write received bytes into the frame buffer and post the length and link-quality byte of the frame. A transmit-side port lets the radio read buffer bytes and the stored frame length. The receive-side port has no back-pressure: a write strobe or a completion pulse is accepted in the cycle it is high, and there is no ready signal.

Top module: `xcvr_spi_access`

## Requirements
- R1: A command byte with bit 7 set is a register access. Bits 5:0 of that byte give the register address, and bit 6 selects write (1) or read (0).
- R2: MOSI is sampled on rising SCLK edges, most significant bit first. MISO changes only after falling SCLK edges. MISO is 0 throughout the command byte.
- R3: On a register read, the addressed value is shifted out on MISO during the second byte, while the host sends 0xFF as filler. A command byte with bit 7 clear and bit 5 clear is ignored: it returns zeros and changes nothing.
- R4: A register write is the command byte followed by one data byte. The data byte is committed only when its eighth bit has arrived. Any further bytes in the same frame are ignored.
- R5: The identification registers are read-only and return fixed values: 0x03 at address 0x1C, 0x02 at 0x1D, 0x1F at 0x1E and 0x00 at 0x1F. Writes to these addresses change nothing.
- R6: The interrupt flag register at address 0x0F gathers the core's `irq_set` pulses by OR. A host SPI read of this register returns its value and then clears it. SPI writes to it are ignored.
- R7: Command 0x60 (bit 7 clear, bit 6 set, bit 5 set) is a buffer write. The second byte is a length, which is stored saturated to 127. The bytes that follow are written to buffer addresses 0, 1, 2 and so on, and the address wraps from 127 back to 0.
- R8: Command 0x20 (bit 7 clear, bit 6 clear, bit 5 set) is a buffer read. The second byte returned is the stored length L. The next L bytes are buffer addresses 0 to L-1. The byte after those is the link-quality byte, and every later byte is 0x00.
- R9: A `rx_we` strobe writes `rx_wdata` to buffer address `rx_waddr`. A `rx_done` pulse stores `rx_len` (saturated to 127) as the frame length and stores `rx_lqi` as the link-quality byte.
- R10: Raising `cs_n` aborts the access in progress. A partly received byte is discarded and is never committed, and the next frame starts again with a command byte.
- R11: `core_rdata` shows the register addressed by `core_raddr` in the same cycle. This includes the identification values and the interrupt flags, and a read through this port never clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| core_raddr | input | 6 | Core-side register view address |
| core_rdata | output | 8 | Core-side register view data |
| irq_set | input | 8 | Interrupt flag set pulses, one bit per flag |
| rx_we | input | 1 | Receive-side buffer write strobe |
| rx_waddr | input | 7 | Receive-side buffer write address |
| rx_wdata | input | 8 | Receive-side buffer write data |
| rx_done | input | 1 | Received frame complete; loads length and link quality |
| rx_len | input | 8 | Received frame length |
| rx_lqi | input | 8 | Received link-quality byte |
| tx_raddr | input | 7 | Transmit-side buffer read address |
| tx_rdata | output | 8 | Transmit-side buffer read data |
| frame_len | output | 7 | Stored frame length |

## Verification
The bench builds the block with its default parameters: a 7-bit buffer address (128 bytes), two synchronizer stages, and the default identification bytes. With a 128-byte buffer, a single buffer-write frame carrying 130 payload bytes reaches the address wrap. Lengths of 200 and 250 reach the saturation at 127. An empty received frame shows the link-quality byte arriving directly after the length byte. With two synchronizer stages, a serial half-period of six core clocks leaves enough margin for mid-byte aborts at arbitrary bit counts to be placed reliably.

// File: rtl/xsa_pkg.sv
package xsa_pkg;

  localparam logic [5:0] ADDR_IRQ  = 6'h0F;
  localparam logic [5:0] ADDR_PART = 6'h1C;
  localparam logic [5:0] ADDR_VER  = 6'h1D;
  localparam logic [5:0] ADDR_MAN0 = 6'h1E;
  localparam logic [5:0] ADDR_MAN1 = 6'h1F;

  typedef enum logic [1:0] {ACC_NONE, ACC_REG, ACC_FB} acc_kind_e;

  typedef enum logic [1:0] {PH_CMD, PH_SECOND, PH_BODY} phase_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic       wr;
    logic [5:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.wr   = b[6];
    c.addr = b[5:0];
    if (b[7])      c.kind = ACC_REG;
    else if (b[5]) c.kind = ACC_FB;
    else           c.kind = ACC_NONE;
    return c;
  endfunction

endpackage

// File: rtl/xsa_pin_sync.sv
module xsa_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic              sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      cs_q      <= '1;
      mosi_q    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[STAGES-2:0], sclk};
      cs_q      <= {cs_q[STAGES-2:0], cs_n};
      mosi_q    <= {mosi_q[STAGES-2:0], mosi};
      sclk_prev <= sclk_q[STAGES-1];
    end
  end

  assign cs_act    = !cs_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];
  assign sclk_rise = cs_act &&  sclk_q[STAGES-1] && !sclk_prev;
  assign sclk_fall = cs_act && !sclk_q[STAGES-1] &&  sclk_prev;
endmodule

// File: rtl/xsa_regbank.sv
module xsa_regbank
  import xsa_pkg::*;
#(
  parameter logic [7:0] PART_ID    = 8'h03,
  parameter logic [7:0] VERSION_ID = 8'h02,
  parameter logic [7:0] MAN_ID_LO  = 8'h1F,
  parameter logic [7:0] MAN_ID_HI  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_we,
  input  logic [5:0] spi_waddr,
  input  logic [7:0] spi_wdata,
  input  logic       spi_rd,
  input  logic [5:0] spi_raddr,
  output logic [7:0] spi_rdata,
  input  logic [7:0] irq_set,
  input  logic [5:0] core_raddr,
  output logic [7:0] core_rdata
);
  localparam int NREG = 64;

  logic [7:0] regs [NREG];
  logic [7:0] irq_q;
  logic       irq_clr;

  assign irq_clr = spi_rd && (spi_raddr == ADDR_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_clr ? 8'h00 : irq_q) | irq_set;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (6'(i) == ADDR_IRQ) begin : g_irq
      assign regs[i] = irq_q;
    end else if (6'(i) == ADDR_PART) begin : g_part
      assign regs[i] = PART_ID;
    end else if (6'(i) == ADDR_VER) begin : g_ver
      assign regs[i] = VERSION_ID;
    end else if (6'(i) == ADDR_MAN0) begin : g_man0
      assign regs[i] = MAN_ID_LO;
    end else if (6'(i) == ADDR_MAN1) begin : g_man1
      assign regs[i] = MAN_ID_HI;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q <= '0;
        else if (spi_we && spi_waddr == 6'(i))   q <= spi_wdata;
      end
      assign regs[i] = q;
    end
  end

  assign spi_rdata  = regs[spi_raddr];
  assign core_rdata = regs[core_raddr];

  // R6: a host read with no concurrent set leaves the flags empty
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && irq_set == 8'h00) |=> (irq_q == 8'h00));
endmodule

// File: rtl/xsa_fbuf.sv
module xsa_fbuf #(
  parameter int FB_AW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_we,
  input  logic [FB_AW-1:0] spi_waddr,
  input  logic [7:0]       spi_wdata,
  input  logic             len_we,
  input  logic [7:0]       len_in,
  input  logic [FB_AW-1:0] spi_raddr,
  output logic [7:0]       spi_rdata,
  input  logic             rx_we,
  input  logic [FB_AW-1:0] rx_waddr,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_done,
  input  logic [7:0]       rx_len,
  input  logic [7:0]       rx_lqi,
  input  logic [FB_AW-1:0] tx_raddr,
  output logic [7:0]       tx_rdata,
  output logic [FB_AW-1:0] len_q,
  output logic [7:0]       lqi_q
);
  localparam int         DEPTH   = 1 << FB_AW;
  localparam logic [7:0] LEN_MAX = 8'(DEPTH - 1);

  function automatic logic [FB_AW-1:0] sat_len(input logic [7:0] v);
    return (v > LEN_MAX) ? LEN_MAX[FB_AW-1:0] : v[FB_AW-1:0];
  endfunction

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem[i] <= '0;
      else if (spi_we && spi_waddr == FB_AW'(i))     mem[i] <= spi_wdata;
      else if (rx_we && rx_waddr == FB_AW'(i))       mem[i] <= rx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      lqi_q <= '0;
    end else begin
      if (len_we)       len_q <= sat_len(len_in);
      else if (rx_done) len_q <= sat_len(rx_len);
      if (rx_done)      lqi_q <= rx_lqi;
    end
  end

  assign spi_rdata = mem[spi_raddr];
  assign tx_rdata  = mem[tx_raddr];

  // R7: an oversized length from the host lands on the ceiling
  assert_len_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && len_in > LEN_MAX) |=> (len_q == LEN_MAX[FB_AW-1:0]));
endmodule

// File: rtl/xsa_access_ctrl.sv
module xsa_access_ctrl
  import xsa_pkg::*;
#(
  parameter int FB_AW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             cs_act,
  input  logic             mosi_s,
  output logic [5:0]       reg_raddr,
  input  logic [7:0]       reg_rdata,
  output logic             reg_rd,
  output logic             reg_we,
  output logic [5:0]       reg_waddr,
  output logic [7:0]       wr_byte,
  input  logic [FB_AW-1:0] fb_len,
  input  logic [7:0]       fb_lqi,
  output logic [FB_AW-1:0] fb_raddr,
  input  logic [7:0]       fb_rdata,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_waddr,
  output logic             len_we,
  output logic             miso
);
  logic [6:0]       rx_sr;
  logic [2:0]       bit_cnt;
  phase_e           phase;
  cmd_t             cmd_q, cmd_now;
  logic [7:0]       tx_sr, pend;
  logic [FB_AW-1:0] ptr, next_k;
  logic             lqi_sent;
  logic             byte_done, fb_rd_mode, fb_wr_mode;
  logic [7:0]       fb_next;
  logic             fb_next_is_lqi;

  assign byte_done  = sclk_rise && (bit_cnt == 3'd7);
  assign wr_byte    = {rx_sr, mosi_s};
  assign cmd_now    = decode_cmd(wr_byte);
  assign fb_rd_mode = (cmd_q.kind == ACC_FB) && !cmd_q.wr;
  assign fb_wr_mode = (cmd_q.kind == ACC_FB) &&  cmd_q.wr;

  assign reg_raddr = cmd_now.addr;
  assign reg_rd    = byte_done && phase == PH_CMD && cmd_now.kind == ACC_REG && !cmd_now.wr;
  assign reg_we    = byte_done && phase == PH_SECOND && cmd_q.kind == ACC_REG && cmd_q.wr;
  assign reg_waddr = cmd_q.addr;
  assign len_we    = byte_done && phase == PH_SECOND && fb_wr_mode;
  assign fb_we     = byte_done && phase == PH_BODY && fb_wr_mode;
  assign fb_waddr  = ptr;

  assign next_k   = (phase == PH_BODY) ? ptr + FB_AW'(1) : '0;
  assign fb_raddr = next_k;

  always_comb begin
    fb_next_is_lqi = !lqi_sent && (next_k == fb_len);
    if (lqi_sent)            fb_next = 8'h00;
    else if (fb_next_is_lqi) fb_next = fb_lqi;
    else                     fb_next = fb_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      bit_cnt  <= '0;
      phase    <= PH_CMD;
      cmd_q    <= '{kind: ACC_NONE, wr: 1'b0, addr: 6'h00};
      tx_sr    <= '0;
      pend     <= '0;
      ptr      <= '0;
      lqi_sent <= 1'b0;
    end else if (!cs_act) begin
      rx_sr    <= '0;
      bit_cnt  <= '0;
      phase    <= PH_CMD;
      cmd_q    <= '{kind: ACC_NONE, wr: 1'b0, addr: 6'h00};
      tx_sr    <= '0;
      pend     <= '0;
      ptr      <= '0;
      lqi_sent <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sr   <= wr_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          unique case (phase)
            PH_CMD: begin
              cmd_q <= cmd_now;
              phase <= PH_SECOND;
              if (cmd_now.kind == ACC_REG && !cmd_now.wr)      pend <= reg_rdata;
              else if (cmd_now.kind == ACC_FB && !cmd_now.wr)  pend <= 8'(fb_len);
              else                                             pend <= 8'h00;
            end
            PH_SECOND: begin
              phase <= PH_BODY;
              if (fb_rd_mode) begin
                pend     <= fb_next;
                lqi_sent <= fb_next_is_lqi;
              end else begin
                pend <= 8'h00;
              end
            end
            PH_BODY: begin
              if (fb_rd_mode || fb_wr_mode) ptr <= ptr + FB_AW'(1);
              if (fb_rd_mode) begin
                pend     <= fb_next;
                lqi_sent <= lqi_sent || fb_next_is_lqi;
              end else begin
                pend <= 8'h00;
              end
            end
            default: phase <= PH_CMD;
          endcase
        end
      end
      if (sclk_fall) begin
        if (bit_cnt == 3'd0) tx_sr <= pend;
        else                 tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[7];

  // R2: the outgoing shifter never moves on a rising serial edge
  assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_act) |=> $stable(tx_sr));

  // R10: dropping chip select returns the frame logic to its start
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == 3'd0 && phase == PH_CMD && tx_sr == 8'h00));

  // R4: one commit per frame, after which only ignored bytes follow
  assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (phase == PH_BODY && !reg_we));
endmodule

// File: rtl/xcvr_spi_access.sv
module xcvr_spi_access #(
  parameter int         FB_AW       = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PART_ID     = 8'h03,
  parameter logic [7:0] VERSION_ID  = 8'h02,
  parameter logic [7:0] MAN_ID_LO   = 8'h1F,
  parameter logic [7:0] MAN_ID_HI   = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  input  logic [5:0]       core_raddr,
  output logic [7:0]       core_rdata,
  input  logic [7:0]       irq_set,
  input  logic             rx_we,
  input  logic [FB_AW-1:0] rx_waddr,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_done,
  input  logic [7:0]       rx_len,
  input  logic [7:0]       rx_lqi,
  input  logic [FB_AW-1:0] tx_raddr,
  output logic [7:0]       tx_rdata,
  output logic [FB_AW-1:0] frame_len
);
  logic             sclk_rise, sclk_fall, cs_act, mosi_s;
  logic [5:0]       reg_raddr, reg_waddr;
  logic [7:0]       reg_rdata, wr_byte, fb_rdata, fb_lqi;
  logic             reg_rd, reg_we, fb_we, len_we;
  logic [FB_AW-1:0] fb_raddr, fb_waddr;

  xsa_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  xsa_access_ctrl #(.FB_AW(FB_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_rd(reg_rd), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .wr_byte(wr_byte),
    .fb_len(frame_len), .fb_lqi(fb_lqi), .fb_raddr(fb_raddr), .fb_rdata(fb_rdata),
    .fb_we(fb_we), .fb_waddr(fb_waddr), .len_we(len_we), .miso(miso)
  );

  xsa_regbank #(
    .PART_ID(PART_ID), .VERSION_ID(VERSION_ID), .MAN_ID_LO(MAN_ID_LO), .MAN_ID_HI(MAN_ID_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .spi_we(reg_we), .spi_waddr(reg_waddr), .spi_wdata(wr_byte),
    .spi_rd(reg_rd), .spi_raddr(reg_raddr), .spi_rdata(reg_rdata),
    .irq_set(irq_set), .core_raddr(core_raddr), .core_rdata(core_rdata)
  );

  xsa_fbuf #(.FB_AW(FB_AW)) u_fbuf (
    .clk(clk), .rst_n(rst_n),
    .spi_we(fb_we), .spi_waddr(fb_waddr), .spi_wdata(wr_byte),
    .len_we(len_we), .len_in(wr_byte),
    .spi_raddr(fb_raddr), .spi_rdata(fb_rdata),
    .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata),
    .rx_done(rx_done), .rx_len(rx_len), .rx_lqi(rx_lqi),
    .tx_raddr(tx_raddr), .tx_rdata(tx_rdata),
    .len_q(frame_len), .lqi_q(fb_lqi)
  );
endmodule

// File: tb/xcvr_spi_access_test.sv
module xcvr_spi_access_test;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [5:0] core_raddr = '0;
  logic [7:0] core_rdata;
  logic [7:0] irq_set = '0;
  logic       rx_we = 1'b0, rx_done = 1'b0;
  logic [6:0] rx_waddr = '0;
  logic [7:0] rx_wdata = '0, rx_len = '0, rx_lqi = '0;
  logic [6:0] tx_raddr = '0;
  logic [7:0] tx_rdata;
  logic [6:0] frame_len;

  always #10 clk = ~clk;

  xcvr_spi_access uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .core_raddr(core_raddr), .core_rdata(core_rdata), .irq_set(irq_set),
    .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata), .rx_done(rx_done),
    .rx_len(rx_len), .rx_lqi(rx_lqi), .tx_raddr(tx_raddr), .tx_rdata(tx_rdata),
    .frame_len(frame_len)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [7:0] m_reg [64];
  logic [7:0] m_fb  [128];
  int         m_len = 0;
  logic [7:0] m_lqi = 8'h00;
  logic [7:0] m_irq = 8'h00;

  logic [7:0] txq [$];
  logic [7:0] rxq [$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input int a);
    case (a)
      'h0F: return m_irq;
      'h1C: return 8'h03;
      'h1D: return 8'h02;
      'h1E: return 8'h1F;
      'h1F: return 8'h00;
      default: return m_reg[a];
    endcase
  endfunction

  function automatic bit model_writable(input int a);
    return !(a == 'h0F || a == 'h1C || a == 'h1D || a == 'h1E || a == 'h1F);
  endfunction

  // sends txq; stops after max_bits when max_bits >= 0
  task automatic spi_frame(input int max_bits);
    int total;
    logic [7:0] cur;
    total = (max_bits >= 0) ? max_bits : txq.size() * 8;
    rxq.delete();
    cur = '0;
    @(negedge clk);
    cs_n = 1'b0;
    for (int n = 0; n < total; n++) begin
      mosi = txq[n / 8][7 - (n % 8)];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      cur = {cur[6:0], miso};
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      if (n % 8 == 7) rxq.push_back(cur);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic reg_wr(input int a, input logic [7:0] d);
    txq = '{8'hC0 | 8'(a), d};
    spi_frame(-1);
    if (model_writable(a)) m_reg[a] = d;
  endtask

  task automatic reg_rd_chk(input int a, input string tag);
    logic [7:0] exp;
    exp = model_read(a);
    txq = '{8'h80 | 8'(a), 8'hFF};
    spi_frame(-1);
    chk({tag, " R2 cmd byte miso"}, rxq[0], 8'h00);
    chk(tag, rxq[1], exp);
    if (a == 'h0F) m_irq = 8'h00;
  endtask

  task automatic core_scan(input string tag);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      core_raddr = 6'(a);
      #1;
      chk($sformatf("%s R11 core addr %02h", tag, a), core_rdata, model_read(a));
    end
  endtask

  task automatic tx_scan(input string tag, input int first, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      tx_raddr = 7'((first + k) % 128);
      #1;
      chk($sformatf("%s buf %0d", tag, (first + k) % 128), tx_rdata, m_fb[(first + k) % 128]);
    end
  endtask

  task automatic fb_write(input logic [7:0] len, input int npay, input logic [7:0] seed);
    txq = '{8'h60, len};
    for (int i = 0; i < npay; i++) txq.push_back(8'(i) ^ seed);
    spi_frame(-1);
    m_len = (len > 8'd127) ? 127 : int'(len);
    for (int i = 0; i < npay; i++) m_fb[i % 128] = 8'(i) ^ seed;
  endtask

  task automatic fb_read_chk(input int extra, input string tag);
    int nb;
    logic [7:0] exp;
    nb = 2 + m_len + 1 + extra;
    txq = '{8'h20};
    for (int i = 1; i < nb; i++) txq.push_back(8'h00);
    spi_frame(-1);
    chk({tag, " R2 cmd byte"}, rxq[0], 8'h00);
    chk({tag, " R8 length byte"}, rxq[1], 8'(m_len));
    for (int k = 0; k < nb - 2; k++) begin
      if (k < m_len)       exp = m_fb[k];
      else if (k == m_len) exp = m_lqi;
      else                 exp = 8'h00;
      chk($sformatf("%s R8 stream byte %0d", tag, k), rxq[2 + k], exp);
    end
  endtask

  task automatic rx_load(input logic [7:0] len, input logic [7:0] lqi, input int nb, input logic [7:0] seed);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_we = 1'b1; rx_waddr = 7'(i); rx_wdata = 8'(i * 3) + seed;
      m_fb[i] = 8'(i * 3) + seed;
    end
    @(negedge clk);
    rx_we = 1'b0;
    rx_done = 1'b1; rx_len = len; rx_lqi = lqi;
    @(negedge clk);
    rx_done = 1'b0;
    m_len = (len > 8'd127) ? 127 : int'(len);
    m_lqi = lqi;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk);
    irq_set = v;
    @(negedge clk);
    irq_set = 8'h00;
    m_irq = m_irq | v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 00 expected 01");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
    for (int i = 0; i < 128; i++) m_fb[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R2 reset miso", {7'd0, miso}, 8'h00);
    chk("R7 reset frame_len", {1'b0, frame_len}, 8'h00);
    core_scan("reset R5");

    // R1 / R4 / R3: write then read back
    reg_wr('h05, 8'hA5);
    reg_rd_chk('h05, "R3 read of 0x05");
    reg_wr('h3F, 8'h5C);                 // R1: cmd 0xFF addresses 0x3F
    reg_rd_chk('h3F, "R1 address bits 5:0");
    reg_rd_chk('h05, "R1 read bit6 clear");

    // R4: extra bytes after the data byte are ignored
    txq = '{8'hC7, 8'h11, 8'h22, 8'h33};
    spi_frame(-1);
    m_reg[7] = 8'h11;
    reg_rd_chk('h07, "R4 three-byte write keeps first data");

    // R10: aborts inside the data byte leave the register untouched
    reg_wr('h06, 8'h3C);
    txq = '{8'hC6, 8'hE1};
    spi_frame(12);
    reg_rd_chk('h06, "R10 abort after 4 data bits");
    spi_frame(15);
    reg_rd_chk('h06, "R10 abort after 7 data bits");
    txq = '{8'hC6};
    spi_frame(5);
    reg_rd_chk('h06, "R10 abort inside command");

    // R5: identification values and write protection
    reg_wr('h1E, 8'hAA);
    reg_wr('h1C, 8'h55);
    reg_rd_chk('h1C, "R5 part id");
    reg_rd_chk('h1D, "R5 version");
    reg_rd_chk('h1E, "R5 maker low");
    reg_rd_chk('h1F, "R5 maker high");

    // R3: non-commands change nothing and return zeros
    txq = '{8'h40, 8'h12, 8'h34};
    spi_frame(-1);
    chk("R3 unknown cmd byte1", rxq[1], 8'h00);
    txq = '{8'h1F, 8'hFF};
    spi_frame(-1);
    chk("R3 unknown cmd byte1 b", rxq[1], 8'h00);
    core_scan("after unknown R3");

    // R6: interrupt flags
    pulse_irq(8'h08);
    pulse_irq(8'h40);
    core_scan("irq pending R6");
    core_scan("irq still pending R6");
    reg_wr('h0F, 8'hFF);
    reg_rd_chk('h0F, "R6 read returns flags");
    reg_rd_chk('h0F, "R6 flags cleared by read");

    // R7: buffer write and stored length
    fb_write(8'd5, 3, 8'hC3);
    chk("R7 stored length", {1'b0, frame_len}, 8'd5);
    tx_scan("R7", 0, 5);
    fb_read_chk(2, "R8 host frame");

    fb_write(8'd200, 0, 8'h00);
    chk("R7 length saturates", {1'b0, frame_len}, 8'd127);

    // R7: buffer address wraps at 128
    fb_write(8'd10, 130, 8'h5A);
    chk("R7 length after wrap frame", {1'b0, frame_len}, 8'd10);
    tx_scan("R7 wrap", 126, 6);

    // R9 / R8: receive side
    rx_load(8'd4, 8'hD7, 6, 8'h21);
    chk("R9 rx length", {1'b0, frame_len}, 8'd4);
    tx_scan("R9", 0, 6);
    fb_read_chk(3, "R9 received frame");
    rx_load(8'd0, 8'h99, 0, 8'h00);
    fb_read_chk(2, "R8 empty frame");
    rx_load(8'd250, 8'h42, 0, 8'h00);
    chk("R9 rx length saturates", {1'b0, frame_len}, 8'd127);

    // R10: abort during a buffer write keeps earlier bytes only
    rx_load(8'd3, 8'h10, 4, 8'h80);
    txq = '{8'h60, 8'd6, 8'hE0, 8'hE1, 8'hE2};
    spi_frame(16 + 8 + 5);
    m_len = 6;
    m_fb[0] = 8'hE0;
    tx_scan("R10 partial buffer write", 0, 3);
    core_scan("final R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule